// File: doc/BRIEF.md
# Linked-Descriptor Frame Mover

This block streams frames out of memory into a packet FIFO by walking a linked list of descriptors that software builds in memory. Each descriptor occupies four consecutive 32-bit words: a control word, the address of the frame buffer, a pointer to the next descriptor, and a status word. The engine reads the first three words, reads the frame data word by word and presents it on a ready/valid stream, writes the status word, and then hands the descriptor back to software by clearing its ownership bit.

Software owns a descriptor while its ownership bit is 0 and the engine owns it while the bit is 1. Two more control bits decide what happens next. One makes the engine follow the next pointer or stop. The other makes the engine keep re-reading a descriptor that software has not yet handed over, so that a closed ring can run with no further start command. A poll gap counter spaces these re-reads. Three interrupt causes, each with its own enable, report a finished frame, a next descriptor that is not yet owned by the engine, and a finished chain.

Software writes the address of the first descriptor into the next-pointer register and then writes the start register. All frames leave in chain order.

Top module: `frame_desc_dma`

## Requirements
- R1: After reset the engine is idle, does not request memory, presents no stream beat, all four registers read 0, and `irq` is low.
- R2: For a descriptor at address D the engine reads D+0, D+4 and D+8 in that order. Control word fields: bit 31 ownership (1 = engine), bit 30 follow-next, bit 29 poll-enable, bits 15:0 frame length in 32-bit words.
- R3: A frame of length L reads words from buffer+4*i for i = 0..L-1 and presents them in that order on the stream, with `fifo_last` high on the final word only. Data is held stable while `fifo_ready` is low. L = 0 produces no beat.
- R4: After the data, the engine writes 0x8000_0000 | L to D+12, then rewrites D+0 with bit 31 cleared and every other bit unchanged, and sets status bit 0 (frame done).
- R5: When follow-next is 0, the engine stops after that descriptor. Status bit 0 and status bit 2 (chain done) become set in the same cycle, and busy falls.
- R6: When follow-next is 1, the engine next fetches the descriptor at the stored next pointer, so frames leave strictly in chain order.
- R7: A fetched control word with ownership 0 and poll-enable 1 sets status bit 1 (next not owned). The engine then makes no memory request for POLL_GAP cycles and re-reads the same descriptor, repeating until ownership is 1. In a ring this never sets status bit 2.
- R8: A fetched control word with ownership 0 and poll-enable 0 sets status bit 2 only, stops the engine, and writes nothing to memory.
- R9: Register map by `reg_sel`: 0 = start (write 1 in bit 0 starts; read bit 0 = busy), 1 = next pointer, 2 = interrupt enable bits 2:0, 3 = interrupt status bits 2:0. Status bits are sticky and are cleared by writing 1. A hardware set in the same cycle as a clear wins.
- R10: `irq` is the OR over the three causes of status AND enable. Any combination of enables may be active.
- R11: While busy, writes to the start and next-pointer registers are ignored.
- R12: A memory request holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory request completed |
| fifo_valid | output | 1 | Stream word valid |
| fifo_data | output | 32 | Stream word |
| fifo_last | output | 1 | Final word of the frame |
| fifo_ready | input | 1 | Stream sink accepts the word |
| irq | output | 1 | Interrupt request |

## Verification
When the last descriptor of an open list completes, the frame-done and chain-done causes both fire in the same cycle. A missed or late chain-done would show up as the two bits appearing one cycle apart. The bench holds the status register selected and samples it every cycle while a single-descriptor list runs, then compares the first cycle each bit was seen. The ring test covers the other end: polling with frames in between must never raise chain-done, and the bench confirms this by sampling status after several polls.

// File: rtl/dma_pkg.sv
// Shared constants and types for the descriptor-chain frame mover.
// Assumes 32-bit words and byte addresses with word-aligned descriptors.
package dma_pkg;
    localparam int WORD      = 32;
    localparam int CTL_OWN   = 31;
    localparam int CTL_NEXT  = 30;
    localparam int CTL_POLL  = 29;
    localparam int IRQ_FRAME = 0;
    localparam int IRQ_NOTOWN = 1;
    localparam int IRQ_CHAIN = 2;
    localparam int NIRQ      = 3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_CTL, ST_RD_BUF, ST_RD_NXT, ST_RD_DATA,
        ST_PUSH, ST_WR_STS, ST_WR_CTL, ST_POLL
    } walk_state_t;
endpackage

// File: rtl/dma_csr.sv
// Register port of the frame mover: start, next pointer, interrupt enable
// and sticky write-1-to-clear status. Assumes hardware set pulses last one cycle.
module dma_csr
    import dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_sel,
    input  logic [WORD-1:0] reg_wdata,
    output logic [WORD-1:0] reg_rdata,
    input  logic            busy,
    input  logic [NIRQ-1:0] hw_set,
    output logic            start,
    output logic [WORD-1:0] next_ptr,
    output logic            irq
);
    logic [NIRQ-1:0] en_q;
    logic [NIRQ-1:0] sts_q;
    logic            wr_idle;

    assign wr_idle = reg_wr && !busy;
    assign start   = wr_idle && (reg_sel == 2'd0) && reg_wdata[0];
    assign irq     = |(sts_q & en_q);

    // Holds the next pointer and enables; pointer writes only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_ptr <= '0;
            en_q     <= '0;
        end else begin
            if (wr_idle && reg_sel == 2'd1) next_ptr <= reg_wdata;
            if (reg_wr && reg_sel == 2'd2)  en_q     <= reg_wdata[NIRQ-1:0];
        end
    end

    // Sticky status: write-1 clears, hardware set wins in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else if (reg_wr && reg_sel == 2'd3) sts_q <= (sts_q & ~reg_wdata[NIRQ-1:0]) | hw_set;
        else sts_q <= sts_q | hw_set;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            2'd0: reg_rdata[0] = busy;
            2'd1: reg_rdata = next_ptr;
            2'd2: reg_rdata[NIRQ-1:0] = en_q;
            default: reg_rdata[NIRQ-1:0] = sts_q;
        endcase
    end

    // R9: no status bit drops without a write to the status register.
    assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == 2'd3) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

// File: rtl/dma_poll_timer.sv
// Gap counter between re-reads of a descriptor not yet owned by the engine.
// Assumes one load pulse per poll; busy is high for GAP cycles after it.
module dma_poll_timer #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(GAP + 2);
    logic [CW-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Loads the gap on a poll and counts it down.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (load) cnt_q <= CW'(GAP);
        else if (busy) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/dma_walker.sv
// Descriptor walker: fetches descriptor words, moves frame words to the stream,
// writes status and returns ownership, then follows, polls or stops.
// Assumes memory returns read data together with mem_ack.
module dma_walker
    import dma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WORD-1:0] start_ptr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [WORD-1:0] mem_addr,
    output logic [WORD-1:0] mem_wdata,
    input  logic [WORD-1:0] mem_rdata,
    input  logic            mem_ack,
    output logic            fifo_valid,
    output logic [WORD-1:0] fifo_data,
    output logic            fifo_last,
    input  logic            fifo_ready,
    output logic            poll_load,
    input  logic            poll_busy,
    output logic            busy,
    output logic [NIRQ-1:0] hw_set
);
    localparam int PADW = WORD - LEN_W - 2;
    localparam int STSW = WORD - 1 - LEN_W;

    walk_state_t      st_q;
    logic [WORD-1:0]  cur_q, ctl_q, buf_q, nxt_q, dat_q;
    logic [LEN_W-1:0] idx_q, len;
    logic             ctl_ack, frame_end;

    assign len       = ctl_q[LEN_W-1:0];
    assign busy      = (st_q != ST_IDLE);
    assign ctl_ack   = (st_q == ST_RD_CTL) && mem_ack;
    assign frame_end = (st_q == ST_WR_CTL) && mem_ack;
    assign poll_load = ctl_ack && !mem_rdata[CTL_OWN] && mem_rdata[CTL_POLL];
    assign fifo_valid = (st_q == ST_PUSH);
    assign fifo_data  = dat_q;
    assign fifo_last  = (idx_q == len - LEN_W'(1));

    // Interrupt cause pulses towards the register block.
    always_comb begin
        hw_set = '0;
        hw_set[IRQ_FRAME]  = frame_end;
        hw_set[IRQ_NOTOWN] = poll_load;
        hw_set[IRQ_CHAIN]  = (frame_end && !ctl_q[CTL_NEXT]) ||
                             (ctl_ack && !mem_rdata[CTL_OWN] && !mem_rdata[CTL_POLL]);
    end

    // Memory request decode from the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        case (st_q)
            ST_RD_CTL:  mem_addr = cur_q;
            ST_RD_BUF:  mem_addr = cur_q + 32'd4;
            ST_RD_NXT:  mem_addr = cur_q + 32'd8;
            ST_RD_DATA: mem_addr = buf_q + {{PADW{1'b0}}, idx_q, 2'b00};
            ST_WR_STS: begin
                mem_we    = 1'b1;
                mem_addr  = cur_q + 32'd12;
                mem_wdata = {1'b1, {STSW{1'b0}}, len};
            end
            ST_WR_CTL: begin
                mem_we    = 1'b1;
                mem_wdata = ctl_q & ~(32'd1 << CTL_OWN);
            end
            default: mem_req = 1'b0;
        endcase
    end

    // Walk state machine and descriptor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cur_q <= '0;
            ctl_q <= '0;
            buf_q <= '0;
            nxt_q <= '0;
            dat_q <= '0;
            idx_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    cur_q <= start_ptr;
                    st_q  <= ST_RD_CTL;
                end
                ST_RD_CTL: if (mem_ack) begin
                    ctl_q <= mem_rdata;
                    if (mem_rdata[CTL_OWN])       st_q <= ST_RD_BUF;
                    else if (mem_rdata[CTL_POLL]) st_q <= ST_POLL;
                    else                          st_q <= ST_IDLE;
                end
                ST_RD_BUF: if (mem_ack) begin
                    buf_q <= mem_rdata;
                    st_q  <= ST_RD_NXT;
                end
                ST_RD_NXT: if (mem_ack) begin
                    nxt_q <= mem_rdata;
                    idx_q <= '0;
                    st_q  <= (len == '0) ? ST_WR_STS : ST_RD_DATA;
                end
                ST_RD_DATA: if (mem_ack) begin
                    dat_q <= mem_rdata;
                    st_q  <= ST_PUSH;
                end
                ST_PUSH: if (fifo_ready) begin
                    if (fifo_last) st_q <= ST_WR_STS;
                    else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_RD_DATA;
                    end
                end
                ST_WR_STS: if (mem_ack) st_q <= ST_WR_CTL;
                ST_WR_CTL: if (mem_ack) begin
                    if (ctl_q[CTL_NEXT]) begin
                        cur_q <= nxt_q;
                        st_q  <= ST_RD_CTL;
                    end else st_q <= ST_IDLE;
                end
                ST_POLL: if (!poll_busy) st_q <= ST_RD_CTL;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R12: request fields hold until acknowledged.
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R3: a stalled stream word stays put.
    assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_valid && !fifo_ready |=> fifo_valid && $stable(fifo_data) && $stable(fifo_last));
endmodule

// File: rtl/frame_desc_dma.sv
// Top of the descriptor-chain frame mover: register block, walker and poll
// gap timer. Assumes a single-cycle-or-longer acknowledged memory port.
module frame_desc_dma
    import dma_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int POLL_GAP = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        fifo_valid,
    output logic [31:0] fifo_data,
    output logic        fifo_last,
    input  logic        fifo_ready,
    output logic        irq
);
    logic            start, busy, poll_load, poll_busy;
    logic [WORD-1:0] next_ptr;
    logic [NIRQ-1:0] hw_set;

    dma_csr u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .hw_set(hw_set), .start(start), .next_ptr(next_ptr), .irq(irq)
    );

    dma_walker #(.LEN_W(LEN_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(next_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_ready(fifo_ready), .poll_load(poll_load), .poll_busy(poll_busy),
        .busy(busy), .hw_set(hw_set)
    );

    dma_poll_timer #(.GAP(POLL_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(poll_load), .busy(poll_busy)
    );

    // R7: the memory port is quiet while the poll gap runs.
    assert_quiet_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_busy |-> !mem_req);
    // R7: a not-owned poll never coincides with frame or chain completion.
    assert_poll_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[IRQ_NOTOWN] |-> !hw_set[IRQ_FRAME] && !hw_set[IRQ_CHAIN]);
    // R1: an idle engine drives neither memory nor stream.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !fifo_valid);
endmodule

// File: tb/sim_frame_desc_dma.sv
module sim_frame_desc_dma;
    localparam int GAP = 8;
    localparam logic [31:0] OWN = 32'h8000_0000, NXT = 32'h4000_0000, POL = 32'h2000_0000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, reg_wr, mem_req, mem_we, mem_ack, fifo_valid, fifo_last, fifo_ready, irq;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata, fifo_data;

    frame_desc_dma #(.POLL_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .fifo_valid(fifo_valid),
        .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_ready(fifo_ready),
        .irq(irq)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic finished = 1'b0;
    logic [31:0] mem [0:255];
    logic [31:0] rd_addr [0:127];
    int          rd_cyc  [0:127];
    logic [31:0] got     [0:15];
    logic        gotl    [0:15];
    int nrd, nwr, ngot;
    logic clr_log, stall, bw_en;
    logic [31:0] bw_addr, bw_data;

    // Memory model with one-cycle acknowledge, read/write log and stream sink.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_rdata <= '0; fifo_ready <= 1'b1;
            nrd <= 0; nwr <= 0; ngot <= 0;
        end else begin
            mem_ack <= 1'b0;
            fifo_ready <= stall ? ~fifo_ready : 1'b1;
            if (bw_en) mem[bw_addr[9:2]] <= bw_data;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    nwr <= nwr + 1;
                end else begin
                    if (nrd < 128) begin rd_addr[nrd] <= mem_addr; rd_cyc[nrd] <= cyc; end
                    nrd <= nrd + 1;
                end
            end
            if (fifo_valid && fifo_ready && ngot < 16) begin
                got[ngot] <= fifo_data; gotl[ngot] <= fifo_last; ngot <= ngot + 1;
            end
            if (clr_log) begin nrd <= 0; nwr <= 0; ngot <= 0; end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
        @(negedge clk); bw_en = 1'b0;
    endtask

    task automatic desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] b, input logic [31:0] n);
        poke(a, c); poke(a + 4, b); poke(a + 8, n); poke(a + 12, 32'h0);
    endtask

    task automatic rwrite(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rread(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk); reg_sel = s; #1 d = reg_rdata;
    endtask

    task automatic clear_log();
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
    endtask

    task automatic wait_bits(input logic [2:0] m, input string req);
        logic [31:0] v;
        int n = 0;
        do begin rread(2'd3, v); n++; end while (((v[2:0] & m) != m) && n < 2000);
        chk(n < 2000, req, v, {29'b0, m});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            rread(s[1:0], v);
            chk(v == 0, "R1 register after reset", v, 0);
        end
        chk(!irq && !mem_req && !fifo_valid, "R1 outputs after reset", {irq, mem_req, fifo_valid}, 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int c_frame = -1, c_chain = -1, n = 0;
        desc(32'h40, OWN | 32'd3, 32'h100, 32'h0);
        poke(32'h100, 32'h11); poke(32'h104, 32'h22); poke(32'h108, 32'h33);
        rwrite(2'd2, 32'd5); clear_log();
        rwrite(2'd1, 32'h40); rwrite(2'd0, 32'd1);
        while (c_chain < 0 && n < 2000) begin
            rread(2'd3, v); n++;
            if (v[0] && c_frame < 0) c_frame = cyc;
            if (v[2] && c_chain < 0) c_chain = cyc;
        end
        chk(c_chain >= 0 && c_frame == c_chain, "R5 frame and chain done same cycle", c_frame, c_chain);
        chk(rd_addr[0] == 32'h40 && rd_addr[1] == 32'h44 && rd_addr[2] == 32'h48, "R2 fetch order", rd_addr[1], 32'h44);
        chk(ngot == 3 && got[0] == 32'h11 && got[1] == 32'h22 && got[2] == 32'h33, "R3 stream words", got[2], 32'h33);
        chk(!gotl[0] && !gotl[1] && gotl[2], "R3 last flag", {gotl[0], gotl[1], gotl[2]}, 1);
        chk(mem[32'h4C >> 2] == 32'h8000_0003, "R4 status word", mem[32'h4C >> 2], 32'h8000_0003);
        chk(mem[32'h40 >> 2] == 32'd3, "R4 ownership returned", mem[32'h40 >> 2], 32'd3);
        rread(2'd0, v);
        chk(v[0] == 1'b0, "R5 busy falls", v, 0);
        chk(irq == 1'b1, "R10 irq with frame+chain enables", irq, 1);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        rwrite(2'd3, 32'd7);
        desc(32'h40, OWN | NXT | 32'd2, 32'h100, 32'h60);
        desc(32'h60, OWN | NXT | 32'd1, 32'h140, 32'h80);
        desc(32'h80, OWN, 32'h0, 32'h0);
        poke(32'h100, 32'hC1); poke(32'h104, 32'hC2); poke(32'h140, 32'hD1);
        rwrite(2'd2, 32'd2);
        stall = 1'b1; clear_log();
        rwrite(2'd1, 32'h40); rwrite(2'd0, 32'd1);
        wait_bits(3'b100, "R5 chain end");
        stall = 1'b0;
        chk(ngot == 3 && got[0] == 32'hC1 && got[1] == 32'hC2 && got[2] == 32'hD1, "R6 chain order data", got[2], 32'hD1);
        chk(!gotl[0] && gotl[1] && gotl[2], "R3 last per frame", {gotl[0], gotl[1], gotl[2]}, 3);
        chk(rd_addr[5] == 32'h60 && rd_addr[9] == 32'h80, "R6 follows next pointer", rd_addr[9], 32'h80);
        chk(mem[32'h8C >> 2] == 32'h8000_0000, "R3 zero-length status", mem[32'h8C >> 2], 32'h8000_0000);
        chk(mem[32'h6C >> 2] == 32'h8000_0001 && mem[32'h60 >> 2] == (NXT | 32'd1), "R4 second descriptor", mem[32'h60 >> 2], NXT | 32'd1);
        chk(irq == 1'b0, "R10 only not-owned enabled", irq, 0);
    endtask

    task automatic t_ring();
        logic [31:0] v;
        int last = -1, polls = 0, gap_ok = 1, n = 0;
        rwrite(2'd3, 32'd7);
        desc(32'h40, OWN | NXT | POL | 32'd1, 32'h200, 32'h60);
        desc(32'h60, NXT | POL | 32'd1, 32'h220, 32'h40);
        poke(32'h200, 32'hA5); poke(32'h220, 32'hB6);
        rwrite(2'd2, 32'd7); clear_log();
        rwrite(2'd1, 32'h40); rwrite(2'd0, 32'd1);
        wait_bits(3'b010, "R7 not-owned raised");
        repeat (40) @(negedge clk);
        for (int i = 0; i < nrd && i < 128; i++)
            if (rd_addr[i] == 32'h60) begin
                if (last >= 0 && rd_cyc[i] - last <= GAP) gap_ok = 0;
                last = rd_cyc[i]; polls++;
            end
        chk(polls >= 2 && gap_ok == 1, "R7 re-reads spaced by gap", polls, 2);
        rwrite(2'd1, 32'h300); rwrite(2'd0, 32'd1);
        rread(2'd1, v);
        chk(v == 32'h40, "R11 next pointer write ignored while busy", v, 32'h40);
        poke(32'h60, OWN | NXT | POL | 32'd1);
        while (ngot < 2 && n < 2000) begin @(negedge clk); n++; end
        chk(ngot == 2 && got[1] == 32'hB6, "R7 proceeds once owned", got[1], 32'hB6);
        repeat (40) @(negedge clk);
        rread(2'd3, v);
        chk(v[2] == 1'b0, "R7 ring never chain done", v, 0);
        rread(2'd0, v);
        chk(v[0] == 1'b1, "R7 still polling", v, 1);
        rwrite(2'd3, 32'd1);
        rread(2'd3, v);
        chk(v[0] == 1'b0 && v[1] == 1'b1, "R9 write-one clears only that bit", v, 2);
        poke(32'h40, NXT | 32'd1);
        wait_bits(3'b100, "R8 ring stopped");
        rread(2'd0, v);
        chk(v[0] == 1'b0 && mem[32'h40 >> 2] == (NXT | 32'd1), "R8 stop without write", mem[32'h40 >> 2], NXT | 32'd1);
        chk(ngot == 2, "R11 start while busy ignored", ngot, 2);
    endtask

    task automatic t_unowned_stop();
        logic [31:0] v;
        rwrite(2'd3, 32'd7);
        desc(32'hA0, 32'h0000_0002, 32'h100, 32'h0);
        rwrite(2'd2, 32'd4); clear_log();
        rwrite(2'd1, 32'hA0); rwrite(2'd0, 32'd1);
        wait_bits(3'b100, "R8 done");
        rread(2'd3, v);
        chk(v == 32'd4 && nwr == 0, "R8 chain done only, no writes", v, 4);
        chk(irq == 1'b1, "R10 chain enable", irq, 1);
        rwrite(2'd2, 32'd2);
        chk(irq == 1'b0, "R10 masked cause", irq, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
        clr_log = 1'b0; stall = 1'b0; bw_en = 1'b0; bw_addr = '0; bw_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_chain();
        t_ring();
        t_unowned_stop();
        finished = 1'b1;
        summary();
    end
endmodule